// File: doc/BRIEF.md
# Debug Packet Type Demultiplexer

This block takes a stream of 16-bit debug flits, framed by valid, ready and a last marker. It delivers each whole packet on one of two outputs. The third flit of every packet carries a type field. If that field holds the register-access code, the packet goes to the register output. Every other type goes to the bypass output. The first flits are held in a small header store until the type flit can be inspected. The chosen output is then fixed for the rest of the packet.

Each output has its own ready. A stalled output therefore holds back only the packet that is travelling to it. A register client can keep working while the bypass path is tied off, and the reverse also holds. Packets leave in the order they arrived. Their flit contents and last markers are not changed.

Top module: `pkt_type_demux`

## Requirements
- R1: A packet of three or more flits is delivered only on the register output when bits [15:14] of its third flit (index 2) equal 2'b00.
- R2: A packet of three or more flits whose third-flit bits [15:14] hold any value other than 2'b00 is delivered only on the bypass output.
- R3: The register and bypass valid outputs are never high in the same cycle.
- R4: Register packets complete while bypass ready is held low permanently. Bypass packets complete while register ready is held low permanently.
- R5: Packets leave in arrival order. Every flit keeps its 16-bit data and its last marker, and no flit is lost or duplicated.
- R6: A packet that ends, by its last marker, before its third flit goes to the bypass output whatever its flits contain.
- R7: After two flits of a packet have been accepted and the third has not yet been offered, the input ready is low and neither output is valid.
- R8: In the first cycle after reset, both output valids are low and the input ready is high.
- R9: While an output is valid and its ready is low, it stays valid, and its data and last marker stay unchanged, in the following cycle.
- R10: In the cycle after the last flit of a packet is transferred on either output, neither output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input flit is offered |
| in_data | input | 16 | Input flit data |
| in_last | input | 1 | Input flit ends its packet |
| in_ready | output | 1 | Input flit is accepted on this cycle |
| out_reg_valid | output | 1 | Register output flit is offered |
| out_reg_data | output | 16 | Register output flit data |
| out_reg_last | output | 1 | Register output flit ends its packet |
| out_reg_ready | input | 1 | Register sink accepts |
| out_byp_valid | output | 1 | Bypass output flit is offered |
| out_byp_data | output | 16 | Bypass output flit data |
| out_byp_last | output | 1 | Bypass output flit ends its packet |
| out_byp_ready | input | 1 | Bypass sink accepts |

## Verification
If the route register is corrupted, the whole rest of a packet lands on the wrong port. This shows at the first output handshake after the type flit, which is at most three cycles after the header is complete. A bad fill or read pointer in the header store appears as a reordered, repeated or missing flit on the very next packet. If the phase goes wrong, both valids may rise together, a stalled flit may change, or the input may hang. Any of these can be seen in the cycle it happens or in the one after it. The sweep covers every packet length from one to six flits and all four type codes, under free-running, random and permanently-blocked ready patterns.

// File: rtl/demux_pkg.sv
package demux_pkg;
   typedef enum logic [1:0] {
      PH_COLLECT = 2'd0,
      PH_FLUSH   = 2'd1,
      PH_PASS    = 2'd2
   } dmx_phase_e;

   typedef enum logic {
      RT_BYPASS = 1'b0,
      RT_REG    = 1'b1
   } dmx_route_e;

   localparam int unsigned DMX_PORTS = 2;
endpackage

// File: rtl/dmx_hdr_hold.sv
module dmx_hdr_hold #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          wr_last,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic          rd_last,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] rd_idx,
   output logic          full
);
   logic [CW-1:0]             cnt_q;
   logic [CW-1:0]             rd_q;
   logic [DEPTH-1:0][W-1:0]   slot_data;
   logic [DEPTH-1:0]          slot_last;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] data_q;
      logic         last_q;
      always_ff @(posedge clk) begin
         if (wr_en && cnt_q == CW'(i)) begin
            data_q <= wr_data;
            last_q <= wr_last;
         end
      end
      assign slot_data[i] = data_q;
      assign slot_last[i] = last_q;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
         rd_q  <= '0;
      end else begin
         if (wr_en) cnt_q <= cnt_q + CW'(1);
         if (rd_en) rd_q  <= rd_q + CW'(1);
      end
   end

   always_comb begin
      rd_data = '0;
      rd_last = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_q == CW'(i)) begin
            rd_data = slot_data[i];
            rd_last = slot_last[i];
         end
      end
   end

   assign cnt    = cnt_q;
   assign rd_idx = rd_q;
   assign full   = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/dmx_type_decode.sv
module dmx_type_decode #(
   parameter int unsigned        W     = 16,
   parameter int unsigned        LSB   = 14,
   parameter int unsigned        TW    = 2,
   parameter logic [TW-1:0]      CODE  = '0,
   parameter logic [TW-1:0]      MASK  = '1
) (
   input  logic [W-1:0] flit,
   output logic         is_reg
);
   logic [TW-1:0] field;
   assign field = flit[LSB +: TW];

   if (MASK == {TW{1'b1}}) begin : g_exact
      assign is_reg = (field == CODE);
   end else begin : g_masked
      assign is_reg = (((field ^ CODE) & MASK) == '0);
   end
endmodule

// File: rtl/dmx_port_steer.sv
module dmx_port_steer #(
   parameter int unsigned W     = 16,
   parameter int unsigned PORTS = 2,
   localparam int unsigned SW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic                      src_valid,
   input  logic [W-1:0]              src_data,
   input  logic                      src_last,
   input  logic [SW-1:0]             sel,
   input  logic [PORTS-1:0]          dst_ready,
   output logic [PORTS-1:0]          dst_valid,
   output logic [PORTS-1:0][W-1:0]   dst_data,
   output logic [PORTS-1:0]          dst_last,
   output logic                      src_ready
);
   logic [PORTS-1:0] hit;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign hit[p]       = (sel == SW'(p));
      assign dst_valid[p] = src_valid && hit[p];
      assign dst_data[p]  = hit[p] ? src_data : '0;
      assign dst_last[p]  = hit[p] && src_last;
   end

   assign src_ready = |(hit & dst_ready);
endmodule

// File: rtl/pkt_type_demux.sv
module pkt_type_demux #(
   parameter int unsigned          FLIT_W    = 16,
   parameter int unsigned          TYPE_FLIT = 2,
   parameter int unsigned          TYPE_LSB  = 14,
   parameter int unsigned          TYPE_W    = 2,
   parameter logic [TYPE_W-1:0]    REG_CODE  = '0,
   parameter logic [TYPE_W-1:0]    REG_MASK  = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [FLIT_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              out_reg_valid,
   output logic [FLIT_W-1:0] out_reg_data,
   output logic              out_reg_last,
   input  logic              out_reg_ready,
   output logic              out_byp_valid,
   output logic [FLIT_W-1:0] out_byp_data,
   output logic              out_byp_last,
   input  logic              out_byp_ready
);
   import demux_pkg::*;

   localparam int unsigned CW    = $clog2(TYPE_FLIT + 1);
   localparam int unsigned P_BYP = 0;
   localparam int unsigned P_REG = 1;

   if (TYPE_FLIT < 1) begin : g_bad_depth
      $error("type flit index must be at least one");
   end
   if (TYPE_LSB + TYPE_W > FLIT_W) begin : g_bad_field
      $error("type field exceeds flit width");
   end

   dmx_phase_e phase_q, phase_d;
   dmx_route_e route_q, route_d;

   logic              wr_en, rd_en, clr;
   logic [FLIT_W-1:0] hold_data;
   logic              hold_last, hold_full;
   logic [CW-1:0]     hold_cnt, hold_rd;
   logic              type_is_reg;

   logic              src_valid, src_last, src_ready;
   logic [FLIT_W-1:0] src_data;
   logic [DMX_PORTS-1:0]             dst_valid, dst_last, dst_ready;
   logic [DMX_PORTS-1:0][FLIT_W-1:0] dst_data;

   dmx_hdr_hold #(.W(FLIT_W), .DEPTH(TYPE_FLIT)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_data (in_data),
      .wr_last (in_last),
      .rd_en   (rd_en),
      .rd_data (hold_data),
      .rd_last (hold_last),
      .cnt     (hold_cnt),
      .rd_idx  (hold_rd),
      .full    (hold_full)
   );

   dmx_type_decode #(
      .W(FLIT_W), .LSB(TYPE_LSB), .TW(TYPE_W), .CODE(REG_CODE), .MASK(REG_MASK)
   ) u_dec (
      .flit   (in_data),
      .is_reg (type_is_reg)
   );

   assign dst_ready[P_BYP] = out_byp_ready;
   assign dst_ready[P_REG] = out_reg_ready;

   dmx_port_steer #(.W(FLIT_W), .PORTS(DMX_PORTS)) u_steer (
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_last  (src_last),
      .sel       (route_q),
      .dst_ready (dst_ready),
      .dst_valid (dst_valid),
      .dst_data  (dst_data),
      .dst_last  (dst_last),
      .src_ready (src_ready)
   );

   always_comb begin
      phase_d   = phase_q;
      route_d   = route_q;
      wr_en     = 1'b0;
      rd_en     = 1'b0;
      clr       = 1'b0;
      src_valid = 1'b0;
      src_data  = '0;
      src_last  = 1'b0;
      in_ready  = 1'b0;
      case (phase_q)
         PH_COLLECT: begin
            in_ready = !hold_full;
            if (in_valid && !hold_full) begin
               wr_en = 1'b1;
               if (in_last) begin
                  route_d = RT_BYPASS;
                  phase_d = PH_FLUSH;
               end
            end else if (in_valid && hold_full) begin
               route_d = type_is_reg ? RT_REG : RT_BYPASS;
               phase_d = PH_FLUSH;
            end
         end
         PH_FLUSH: begin
            src_valid = 1'b1;
            src_data  = hold_data;
            src_last  = hold_last;
            if (src_ready) begin
               rd_en = 1'b1;
               if ((hold_rd + CW'(1)) == hold_cnt) begin
                  clr     = 1'b1;
                  phase_d = hold_last ? PH_COLLECT : PH_PASS;
               end
            end
         end
         PH_PASS: begin
            src_valid = in_valid;
            src_data  = in_data;
            src_last  = in_last;
            in_ready  = src_ready;
            if (in_valid && src_ready && in_last) phase_d = PH_COLLECT;
         end
         default: phase_d = PH_COLLECT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_COLLECT;
         route_q <= RT_BYPASS;
      end else begin
         phase_q <= phase_d;
         route_q <= route_d;
      end
   end

   assign out_reg_valid = dst_valid[P_REG];
   assign out_reg_data  = dst_data[P_REG];
   assign out_reg_last  = dst_last[P_REG];
   assign out_byp_valid = dst_valid[P_BYP];
   assign out_byp_data  = dst_data[P_BYP];
   assign out_byp_last  = dst_last[P_BYP];
endmodule

// File: rtl/pkt_type_demux_chk.sv
module pkt_type_demux_chk #(
   parameter int unsigned FLIT_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_reg_valid,
   input logic [FLIT_W-1:0] out_reg_data,
   input logic              out_reg_last,
   input logic              out_reg_ready,
   input logic              out_byp_valid,
   input logic [FLIT_W-1:0] out_byp_data,
   input logic              out_byp_last,
   input logic              out_byp_ready
);
   a_r3_one_output: assert property (@(posedge clk) disable iff (rst)
      !(out_reg_valid && out_byp_valid));

   a_r9_reg_hold: assert property (@(posedge clk) disable iff (rst)
      out_reg_valid && !out_reg_ready |=>
         out_reg_valid && $stable(out_reg_data) && $stable(out_reg_last));

   a_r9_byp_hold: assert property (@(posedge clk) disable iff (rst)
      out_byp_valid && !out_byp_ready |=>
         out_byp_valid && $stable(out_byp_data) && $stable(out_byp_last));

   a_r10_gap_after_last: assert property (@(posedge clk) disable iff (rst)
      (out_reg_valid && out_reg_ready && out_reg_last) ||
      (out_byp_valid && out_byp_ready && out_byp_last) |=>
         !out_reg_valid && !out_byp_valid);

   a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_reg_valid && !out_byp_valid && in_ready);

   a_r5_pass_handshake: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && (out_reg_valid || out_byp_valid) |->
         (out_reg_valid && out_reg_ready) || (out_byp_valid && out_byp_ready));
endmodule

bind pkt_type_demux pkt_type_demux_chk #(.FLIT_W(FLIT_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .out_reg_valid (out_reg_valid),
   .out_reg_data  (out_reg_data),
   .out_reg_last  (out_reg_last),
   .out_reg_ready (out_reg_ready),
   .out_byp_valid (out_byp_valid),
   .out_byp_data  (out_byp_data),
   .out_byp_last  (out_byp_last),
   .out_byp_ready (out_byp_ready)
);

// File: tb/test_pkt_type_demux.sv
`timescale 1ns/1ps
module test_pkt_type_demux;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        in_ready;
   logic        out_reg_valid, out_reg_last;
   logic [15:0] out_reg_data;
   logic        out_reg_ready = 1'b0;
   logic        out_byp_valid, out_byp_last;
   logic [15:0] out_byp_data;
   logic        out_byp_ready = 1'b0;

   int unsigned n_cmp  = 0;
   int unsigned n_fail = 0;
   int unsigned cyc    = 0;
   int          mode   = 0;
   bit          running = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // entry: {mode_tag[1:0], short, route_reg, last, data[15:0]}
   logic [20:0] expq [$];

   always #5 clk = ~clk;

   pkt_type_demux i_pkt_type_demux (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .out_reg_valid(out_reg_valid), .out_reg_data(out_reg_data),
      .out_reg_last(out_reg_last), .out_reg_ready(out_reg_ready),
      .out_byp_valid(out_byp_valid), .out_byp_data(out_byp_data),
      .out_byp_last(out_byp_last), .out_byp_ready(out_byp_ready)
   );

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   // output ready patterns, changed just after each rising edge
   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      case (mode)
         0: begin out_reg_ready = 1'b1;    out_byp_ready = 1'b1;    end
         1: begin out_reg_ready = lfsr[0]; out_byp_ready = lfsr[5]; end
         2: begin out_reg_ready = lfsr[2]; out_byp_ready = 1'b0;    end
         default: begin out_reg_ready = 1'b0; out_byp_ready = lfsr[7]; end
      endcase
   end

   // monitor at the falling edge
   logic        p_reg_stall = 1'b0, p_byp_stall = 1'b0, p_end = 1'b0;
   logic [16:0] p_reg_flit = '0, p_byp_flit = '0;

   task automatic take(input bit got_reg, input logic [15:0] d, input logic l);
      logic [20:0] e;
      n_cmp = n_cmp + 1;
      if (expq.size() == 0) begin
         n_fail = n_fail + 1;
         $display("FAIL R5 unexpected flit: actual %h expected none", d);
         return;
      end
      e = expq.pop_front();
      if (got_reg != e[17]) begin
         n_fail = n_fail + 1;
         if (e[19:18] != 2'd0)
            $display("FAIL R4 route: actual reg=%0b expected reg=%0b", got_reg, e[17]);
         else if (e[18])
            $display("FAIL R6 route: actual reg=%0b expected reg=%0b", got_reg, e[17]);
         else if (e[17])
            $display("FAIL R1 route: actual reg=%0b expected reg=%0b", got_reg, e[17]);
         else
            $display("FAIL R2 route: actual reg=%0b expected reg=%0b", got_reg, e[17]);
      end
      n_cmp = n_cmp + 1;
      if ({l, d} != e[16:0]) begin
         n_fail = n_fail + 1;
         $display("FAIL R5 flit: actual %b_%h expected %b_%h", l, d, e[16], e[15:0]);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         n_cmp = n_cmp + 1;
         if (out_reg_valid && out_byp_valid) begin
            n_fail = n_fail + 1;
            $display("FAIL R3 both valid: actual 11 expected not both");
         end
         if (p_reg_stall) begin
            n_cmp = n_cmp + 1;
            if (!out_reg_valid || {out_reg_last, out_reg_data} != p_reg_flit) begin
               n_fail = n_fail + 1;
               $display("FAIL R9 reg hold: actual %b_%b_%h expected 1_%h",
                        out_reg_valid, out_reg_last, out_reg_data, p_reg_flit);
            end
         end
         if (p_byp_stall) begin
            n_cmp = n_cmp + 1;
            if (!out_byp_valid || {out_byp_last, out_byp_data} != p_byp_flit) begin
               n_fail = n_fail + 1;
               $display("FAIL R9 bypass hold: actual %b_%b_%h expected 1_%h",
                        out_byp_valid, out_byp_last, out_byp_data, p_byp_flit);
            end
         end
         if (p_end) begin
            n_cmp = n_cmp + 1;
            if (out_reg_valid || out_byp_valid) begin
               n_fail = n_fail + 1;
               $display("FAIL R10 gap: actual valids %b%b expected 00",
                        out_reg_valid, out_byp_valid);
            end
         end
         if (out_reg_valid && out_reg_ready) take(1'b1, out_reg_data, out_reg_last);
         if (out_byp_valid && out_byp_ready) take(1'b0, out_byp_data, out_byp_last);
         p_reg_stall = out_reg_valid && !out_reg_ready;
         p_byp_stall = out_byp_valid && !out_byp_ready;
         p_reg_flit  = {out_reg_last, out_reg_data};
         p_byp_flit  = {out_byp_last, out_byp_data};
         p_end = (out_reg_valid && out_reg_ready && out_reg_last) ||
                 (out_byp_valid && out_byp_ready && out_byp_last);
      end
   end

   // caller is aligned one time unit after a rising edge
   task automatic send_pkt(input int len, input logic [1:0] typ, input int pid,
                           input bit pause);
      bit is_reg;
      is_reg = (len >= 3) && (typ == 2'b00);
      for (int k = 0; k < len; k++) begin
         bit acc;
         in_valid = 1'b1;
         in_data  = {(k == 2) ? typ : ~typ, 6'(pid), 8'(k)};
         in_last  = (k == len - 1);
         expq.push_back({2'(mode >= 2 ? mode - 1 : 0), (len < 3), is_reg, in_last, in_data});
         acc = 1'b0;
         while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
         end
         if (pause && k == 1 && len >= 3) begin
            in_valid = 1'b0;
            for (int w = 0; w < 4; w++) begin
               @(negedge clk);
               n_cmp = n_cmp + 1;
               if (in_ready || out_reg_valid || out_byp_valid) begin
                  n_fail = n_fail + 1;
                  $display("FAIL R7 held header: actual rdy=%b valids=%b%b expected 0 00",
                           in_ready, out_reg_valid, out_byp_valid);
               end
               @(posedge clk);
               #1;
            end
         end
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int g = 0; g < (pid % 3); g++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic drain();
      for (int t = 0; t < 400 && expq.size() != 0; t++) @(posedge clk);
      #1;
      n_cmp = n_cmp + 1;
      if (expq.size() != 0) begin
         n_fail = n_fail + 1;
         $display("FAIL R5 lost flits: actual pending=%0d expected 0", expq.size());
      end
   endtask

   initial begin
      int pid;
      pid = 0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      n_cmp = n_cmp + 1;
      if (!in_ready || out_reg_valid || out_byp_valid) begin
         n_fail = n_fail + 1;
         $display("FAIL R8 reset state: actual rdy=%b valids=%b%b expected 1 00",
                  in_ready, out_reg_valid, out_byp_valid);
      end
      running = 1'b1;
      @(posedge clk);
      #1;
      // modes 0 and 1: every length 1..6 with every type code
      for (int m = 0; m < 2; m++) begin
         mode = m;
         for (int len = 1; len <= 6; len++)
            for (int t = 0; t < 4; t++) begin
               send_pkt(len, 2'(t), pid, (pid % 4) == 1);
               pid++;
            end
         drain();
      end
      // mode 2: bypass blocked, register packets only (R4)
      mode = 2;
      for (int len = 3; len <= 6; len++) begin
         send_pkt(len, 2'b00, pid, 1'b0);
         pid++;
      end
      drain();
      // mode 3: register blocked, bypass packets only (R4)
      mode = 3;
      for (int len = 1; len <= 6; len++) begin
         send_pkt(len, (len < 3) ? 2'b00 : 2'(1 + (len % 3)), pid, 1'b0);
         pid++;
      end
      drain();
      running = 1'b0;
      summary();
      $finish;
   end
endmodule